// File: doc/BRIEF.md
# Banked Program Memory Mapper

This block sits between a CPU and a cartridge program ROM. It watches CPU writes to the upper half of the address space and keeps a small set of bank registers: one program bank register, four character bank registers and a nametable mirroring bit. It also translates a CPU read inside the 32 KB window at 0x8000–0xFFFF into a physical program ROM address. The read path is purely combinational, so the translation follows the register contents with no added latency.

The window is split into four 8 KB slots. A static mode input picks one of two layouts over the same register set. In the narrow layout, slot 0 is switchable and the other three slots are fixed near the end of the ROM. In the wide layout, slots 0 and 1 form one switchable 16 KB pair, and slots 2 and 3 are fixed to the last two banks. Program and character ROM sizes are parameters, and every bank number is masked to the size of the ROM it selects.

Top module: `bank_mapper`

## Requirements
- R1: While reset is low, all four character banks read 0 and mirrorHorz reads 0. After reset the program register is 0, so in narrow mode a read at 0x8123 maps to physical address 0x00123.
- R2: A write whose address bits 15:12 equal 0xA loads the program register from wrData.
- R3: Writes with address bits 15:12 equal to 0xB, 0xC, 0xD and 0xE load chrBankLeftA, chrBankLeftB, chrBankRightA and chrBankRightB. The stored value is wrData ANDed with (CHR_KB/4 − 1). No other write changes these registers.
- R4: A write with address bits 15:12 equal to 0xF sets mirrorHorz to bit 0 of wrData. A value of 1 means horizontal mirroring and 0 means vertical.
- R5: For a read, rdAddr[14:13] selects the slot. prgAddr equals the slot's bank number shifted left by 13, ORed with rdAddr[12:0].
- R6: In narrow mode (wideMode = 0), the banks for slots 0 to 3 are the program register, 0xFD, 0xFE and 0xFF.
- R7: In wide mode (wideMode = 1), the banks for slots 0 to 3 are twice the program register, twice the program register plus one, 0xFE and 0xFF.
- R8: Every program bank number is ANDed with (PRG_KB/8 − 1) before it is used. For example, with a 128 KB ROM the fixed banks 0xFD, 0xFE and 0xFF become 13, 14 and 15.
- R9: A register write is visible on the read translation on the first clock cycle after the write cycle.
- R10: Writes with address bit 15 low, and writes with address bits 15:12 equal to 0x8 or 0x9, leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wideMode | input | 1 | Layout select: 0 = 8 KB switchable slot, 1 = 16 KB switchable pair; static during operation |
| wrEn | input | 1 | CPU write strobe, one cycle per write |
| wrAddrHi | input | 4 | CPU write address bits 15:12 |
| wrData | input | 8 | CPU write data |
| rdAddr | input | 15 | CPU read address bits 14:0 inside the 0x8000–0xFFFF window |
| prgAddr | output | 21 | Physical program ROM address; bits above the ROM size stay 0 |
| chrBankLeftA | output | 8 | Character bank register for address bits 15:12 = 0xB |
| chrBankLeftB | output | 8 | Character bank register for address bits 15:12 = 0xC |
| chrBankRightA | output | 8 | Character bank register for address bits 15:12 = 0xD |
| chrBankRightB | output | 8 | Character bank register for address bits 15:12 = 0xE |
| mirrorHorz | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
The properties assume that wideMode changes only while reset is held, and that wrAddrHi and wrData carry known values whenever wrEn is high. The fixed-slot and mask properties also assume that PRG_KB and CHR_KB are powers of two. The stimulus sets the mode only inside a reset pulse and drives every input on the falling clock edge. A write strobe never stays high for more than one cycle, and it is never asserted in the same cycle that a read result is sampled, so each sampled translation reflects only completed writes.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

  // Number of character bank registers
  localparam int NUM_CHR = 4;

  // Write decode values on CPU address bits 15:12
  localparam logic [3:0] SEL_PRG     = 4'hA;
  localparam logic [3:0] SEL_CHR_LA  = 4'hB;
  localparam logic [3:0] SEL_CHR_LB  = 4'hC;
  localparam logic [3:0] SEL_CHR_RA  = 4'hD;
  localparam logic [3:0] SEL_CHR_RB  = 4'hE;
  localparam logic [3:0] SEL_MIRR    = 4'hF;

  // Fixed bank numbers before masking
  localparam logic [7:0] PIN_LOW  = 8'hFD;
  localparam logic [7:0] PIN_MID  = 8'hFE;
  localparam logic [7:0] PIN_LAST = 8'hFF;

  // Load strobes from control to datapath
  typedef struct packed {
    logic               prgLoad;
    logic [NUM_CHR-1:0] chrLoad;
    logic               mirrLoad;
  } strobe_t;

  // Unmasked bank number for one slot under the chosen layout
  function automatic logic [7:0] slotRaw(input logic wide,
                                         input logic [7:0] prgReg,
                                         input logic [1:0] slot);
    logic [7:0] res;
    if (wide) begin
      unique case (slot)
        2'd0:    res = {prgReg[6:0], 1'b0};
        2'd1:    res = {prgReg[6:0], 1'b1};
        2'd2:    res = PIN_MID;
        default: res = PIN_LAST;
      endcase
    end else begin
      unique case (slot)
        2'd0:    res = prgReg;
        2'd1:    res = PIN_LOW;
        2'd2:    res = PIN_MID;
        default: res = PIN_LAST;
      endcase
    end
    return res;
  endfunction

endpackage

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import bank_mapper_pkg::*;
(
  input  logic       wrEn,
  input  logic [3:0] wrAddrHi,
  output strobe_t    stb
);

  // Only the upper half of the address map is decoded; 0x8 and 0x9 fall to default
  always_comb begin
    stb = '0;
    if (wrEn && wrAddrHi[3]) begin
      unique case (wrAddrHi)
        SEL_PRG:    stb.prgLoad    = 1'b1;
        SEL_CHR_LA: stb.chrLoad[0] = 1'b1;
        SEL_CHR_LB: stb.chrLoad[1] = 1'b1;
        SEL_CHR_RA: stb.chrLoad[2] = 1'b1;
        SEL_CHR_RB: stb.chrLoad[3] = 1'b1;
        SEL_MIRR:   stb.mirrLoad   = 1'b1;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/bank_datapath.sv
module bank_datapath
  import bank_mapper_pkg::*;
#(
  parameter int PRG_KB = 128,
  parameter int CHR_KB = 128
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [7:0]              wrData,
  input  logic                    wideMode,
  input  logic [14:0]             rdAddr,
  output logic [20:0]             prgAddr,
  output logic [NUM_CHR-1:0][7:0] chrBank,
  output logic                    mirrorHorz
);

  localparam logic [7:0] PRG_MASK = 8'(PRG_KB / 8 - 1);
  localparam logic [7:0] CHR_MASK = 8'(CHR_KB / 4 - 1);

  logic [7:0]      prgReg;
  logic [3:0][7:0] slotBank;
  logic [7:0]      selBank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            prgReg <= '0;
    else if (stb.prgLoad) prgReg <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             mirrorHorz <= 1'b0;
    else if (stb.mirrLoad) mirrorHorz <= wrData[0];
  end

  for (genvar i = 0; i < NUM_CHR; i++) begin : g_chr
    logic [7:0] bankQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               bankQ <= '0;
      else if (stb.chrLoad[i]) bankQ <= wrData & CHR_MASK;
    end
    assign chrBank[i] = bankQ;
  end

  // Slot table follows the live register value combinationally
  for (genvar s = 0; s < 4; s++) begin : g_slot
    assign slotBank[s] = slotRaw(wideMode, prgReg, 2'(s)) & PRG_MASK;
  end

  assign selBank = slotBank[rdAddr[14:13]];
  assign prgAddr = {selBank, rdAddr[12:0]};

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter int PRG_KB = 128,
  parameter int CHR_KB = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wideMode,
  input  logic        wrEn,
  input  logic [3:0]  wrAddrHi,
  input  logic [7:0]  wrData,
  input  logic [14:0] rdAddr,
  output logic [20:0] prgAddr,
  output logic [7:0]  chrBankLeftA,
  output logic [7:0]  chrBankLeftB,
  output logic [7:0]  chrBankRightA,
  output logic [7:0]  chrBankRightB,
  output logic        mirrorHorz
);

  strobe_t                 stb;
  logic [NUM_CHR-1:0][7:0] chrBank;

  bank_ctrl u_ctrl (
    .wrEn     (wrEn),
    .wrAddrHi (wrAddrHi),
    .stb      (stb)
  );

  bank_datapath #(.PRG_KB(PRG_KB), .CHR_KB(CHR_KB)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .wideMode   (wideMode),
    .rdAddr     (rdAddr),
    .prgAddr    (prgAddr),
    .chrBank    (chrBank),
    .mirrorHorz (mirrorHorz)
  );

  assign chrBankLeftA  = chrBank[0];
  assign chrBankLeftB  = chrBank[1];
  assign chrBankRightA = chrBank[2];
  assign chrBankRightB = chrBank[3];

endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
  parameter int PRG_KB = 128,
  parameter int CHR_KB = 128
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [3:0]  wrAddrHi,
  input logic [7:0]  wrData,
  input logic [14:0] rdAddr,
  input logic [20:0] prgAddr,
  input logic [7:0]  chrBankLeftA,
  input logic [7:0]  chrBankLeftB,
  input logic [7:0]  chrBankRightA,
  input logic [7:0]  chrBankRightB,
  input logic        mirrorHorz
);

  localparam logic [7:0] PRG_MASK = 8'(PRG_KB / 8 - 1);
  localparam logic [7:0] CHR_MASK = 8'(CHR_KB / 4 - 1);

  logic ignoredWr;
  assign ignoredWr = wrEn && (!wrAddrHi[3] || (wrAddrHi[3:1] == 3'b100));

  // R4
  mirror_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddrHi == 4'hF) |=> (mirrorHorz == $past(wrData[0])));

  // R10
  ignore_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ignoredWr |=> ($stable(chrBankLeftA) && $stable(chrBankLeftB) &&
                   $stable(chrBankRightA) && $stable(chrBankRightB) &&
                   $stable(mirrorHorz)));

  // R3
  chr_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(chrBankLeftA) && $stable(chrBankLeftB) &&
               $stable(chrBankRightA) && $stable(chrBankRightB)));

  // R3
  chr_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((chrBankLeftA | chrBankLeftB | chrBankRightA | chrBankRightB) & ~CHR_MASK) == 8'h00);

  // R5
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    prgAddr[12:0] == rdAddr[12:0]);

  // R6
  top_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr[14:13] == 2'b11) |-> (prgAddr[20:13] == (8'hFF & PRG_MASK)));

  // R8
  prg_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prgAddr[20:13] & ~PRG_MASK) == 8'h00);

endmodule

bind bank_mapper bank_mapper_chk #(.PRG_KB(PRG_KB), .CHR_KB(CHR_KB)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .wrEn          (wrEn),
  .wrAddrHi      (wrAddrHi),
  .wrData        (wrData),
  .rdAddr        (rdAddr),
  .prgAddr       (prgAddr),
  .chrBankLeftA  (chrBankLeftA),
  .chrBankLeftB  (chrBankLeftB),
  .chrBankRightA (chrBankRightA),
  .chrBankRightB (chrBankRightB),
  .mirrorHorz    (mirrorHorz)
);

// File: tb/bank_mapper_test.sv
module bank_mapper_test;

  localparam int CLK_PERIOD = 10;
  localparam int PRG_KB = 128;
  localparam int CHR_KB = 128;
  localparam int PRG_MASK = PRG_KB / 8 - 1;
  localparam int CHR_MASK = CHR_KB / 4 - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wideMode = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddrHi = '0;
  logic [7:0]  wrData = '0;
  logic [14:0] rdAddr = '0;
  logic [20:0] prgAddr;
  logic [7:0]  chrBankLeftA, chrBankLeftB, chrBankRightA, chrBankRightB;
  logic        mirrorHorz;

  typedef struct {
    int    kind;   // 0 program address, 1 character bank, 2 mirroring
    int    idx;
    int    exp;
    string tag;
  } item_t;

  item_t sbq[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  bank_mapper #(.PRG_KB(PRG_KB), .CHR_KB(CHR_KB)) uut (
    .clk           (clk),
    .rstN          (rstN),
    .wideMode      (wideMode),
    .wrEn          (wrEn),
    .wrAddrHi      (wrAddrHi),
    .wrData        (wrData),
    .rdAddr        (rdAddr),
    .prgAddr       (prgAddr),
    .chrBankLeftA  (chrBankLeftA),
    .chrBankLeftB  (chrBankLeftB),
    .chrBankRightA (chrBankRightA),
    .chrBankRightB (chrBankRightB),
    .mirrorHorz    (mirrorHorz)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Reference model taken from the requirements
  function automatic int expPrg(input bit wide, input int prgVal, input int a);
    int bank;
    int slot;
    slot = (a >> 13) & 3;
    if (wide) begin
      case (slot)
        0:       bank = (prgVal * 2) & 255;
        1:       bank = (prgVal * 2 + 1) & 255;
        2:       bank = 'hFE;
        default: bank = 'hFF;
      endcase
    end else begin
      case (slot)
        0:       bank = prgVal;
        1:       bank = 'hFD;
        2:       bank = 'hFE;
        default: bank = 'hFF;
      endcase
    end
    bank = bank & PRG_MASK;
    return bank * 8192 + (a & 'h1FFF);
  endfunction

  // Driver tasks
  task automatic applyReset(input bit wide);
    @(negedge clk);
    rstN = 1'b0;
    wideMode = wide;
    wrEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeReg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrAddrHi = a[15:12];
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic expectPrg(input logic [15:0] a, input int exp, input string tag);
    item_t it;
    @(negedge clk);
    rdAddr = a[14:0];
    it = '{0, 0, exp, tag};
    sbq.push_back(it);
  endtask

  task automatic expectChr(input int idx, input int exp, input string tag);
    item_t it;
    @(negedge clk);
    it = '{1, idx, exp, tag};
    sbq.push_back(it);
  endtask

  task automatic expectMirr(input int exp, input string tag);
    item_t it;
    @(negedge clk);
    it = '{2, 0, exp, tag};
    sbq.push_back(it);
  endtask

  // The read is sampled in the first cycle after the write cycle
  task automatic writeThenRead(input logic [15:0] a, input logic [7:0] d,
                               input logic [15:0] ra, input int exp, input string tag);
    item_t it;
    @(negedge clk);
    wrEn = 1'b1;
    wrAddrHi = a[15:12];
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    rdAddr = ra[14:0];
    it = '{0, 0, exp, tag};
    sbq.push_back(it);
  endtask

  // Monitor: pops expected items and compares them a quarter period after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD / 4);
      while (sbq.size() > 0) begin
        item_t it;
        int    act;
        it = sbq.pop_front();
        case (it.kind)
          0: act = int'(prgAddr);
          1: begin
            case (it.idx)
              0:       act = int'(chrBankLeftA);
              1:       act = int'(chrBankLeftB);
              2:       act = int'(chrBankRightA);
              default: act = int'(chrBankRightB);
            endcase
          end
          default: act = int'(mirrorHorz);
        endcase
        checks++;
        if (act != it.exp) begin
          errors++;
          $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int prgVal;

    // ---------------- narrow layout ----------------
    applyReset(1'b0);
    expectChr(0, 0, "R1 reset chrBankLeftA");
    expectChr(1, 0, "R1 reset chrBankLeftB");
    expectChr(2, 0, "R1 reset chrBankRightA");
    expectChr(3, 0, "R1 reset chrBankRightB");
    expectMirr(0, "R1 reset mirroring vertical");
    expectPrg(16'h8123, 'h00123, "R1 reset program bank");

    prgVal = 5;
    writeReg(16'hA000, 8'(prgVal));
    expectPrg(16'h8456, expPrg(0, prgVal, 'h8456), "R2 R6 slot0 narrow");
    expectPrg(16'hA010, expPrg(0, prgVal, 'hA010), "R6 slot1 fixed");
    expectPrg(16'hC000, expPrg(0, prgVal, 'hC000), "R6 slot2 fixed");
    expectPrg(16'hFFFF, expPrg(0, prgVal, 'hFFFF), "R5 R6 slot3 top byte");

    prgVal = 'h37;
    writeReg(16'hA5A5, 8'(prgVal));
    expectPrg(16'h9ABC, expPrg(0, prgVal, 'h9ABC), "R8 program bank masked");

    writeReg(16'hB000, 8'h21);
    writeReg(16'hC123, 8'h1F);
    writeReg(16'hD000, 8'h40);
    writeReg(16'hEFFF, 8'h0A);
    expectChr(0, 'h21 & CHR_MASK, "R3 chrBankLeftA masked");
    expectChr(1, 'h1F & CHR_MASK, "R3 chrBankLeftB");
    expectChr(2, 'h40 & CHR_MASK, "R3 chrBankRightA masked");
    expectChr(3, 'h0A & CHR_MASK, "R3 chrBankRightB");

    writeReg(16'hF000, 8'h03);
    expectMirr(1, "R4 horizontal on bit0 set");
    writeReg(16'hF800, 8'h02);
    expectMirr(0, "R4 vertical on bit0 clear");
    writeReg(16'hF000, 8'h01);

    // Ignored writes: low half of the map and decode values 0x8 and 0x9
    writeReg(16'h3000, 8'hFF);
    writeReg(16'h7000, 8'h00);
    writeReg(16'h2000, 8'hFF);
    writeReg(16'h8000, 8'hFF);
    writeReg(16'h9FFF, 8'hFF);
    expectChr(0, 'h21 & CHR_MASK, "R10 chrBankLeftA untouched");
    expectChr(3, 'h0A & CHR_MASK, "R10 chrBankRightB untouched");
    expectMirr(1, "R10 mirroring untouched");
    expectPrg(16'h8000, expPrg(0, prgVal, 'h8000), "R10 program bank untouched");

    prgVal = 3;
    writeThenRead(16'hA000, 8'(prgVal), 16'h8042, expPrg(0, prgVal, 'h8042),
                  "R9 next cycle narrow");

    // ---------------- wide layout ----------------
    applyReset(1'b1);
    expectPrg(16'h8000, expPrg(1, 0, 'h8000), "R1 reset wide slot0");
    prgVal = 3;
    writeReg(16'hA000, 8'(prgVal));
    expectPrg(16'h8111, expPrg(1, prgVal, 'h8111), "R7 slot0 even bank");
    expectPrg(16'hA222, expPrg(1, prgVal, 'hA222), "R7 slot1 odd bank");
    expectPrg(16'hC333, expPrg(1, prgVal, 'hC333), "R7 slot2 fixed");
    expectPrg(16'hE444, expPrg(1, prgVal, 'hE444), "R7 slot3 fixed");

    prgVal = 'h86;
    writeReg(16'hA000, 8'(prgVal));
    expectPrg(16'h8000, expPrg(1, prgVal, 'h8000), "R7 R8 pair masked even");
    expectPrg(16'hBFFF, expPrg(1, prgVal, 'hBFFF), "R7 R8 pair masked odd");

    prgVal = 'h0B;
    writeThenRead(16'hA000, 8'(prgVal), 16'hA001, expPrg(1, prgVal, 'hA001),
                  "R9 next cycle wide");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule